// File: doc/BRIEF.md
# Dual-Clock Timer Synchronization Bridge

This block is an 8-bit timer/counter that counts on a slow, free-running timer clock. It is programmed and observed from a much faster bus clock. Software writes three registers through a single bus write port: control, counter and compare. Each write is staged on the bus side and handed to the timer domain through a toggle handshake. Each register has its own busy bit, and software polls that bit to learn when the value has taken effect.

The counter is read through a snapshot register in the bus domain. The snapshot is reloaded once per timer-clock edge and can therefore be stale by a few bus cycles. A compare match toggles an event in the timer domain, and the block resynchronizes that event into a sticky interrupt flag on the bus side. The match can also toggle an output pin that is driven straight from the timer clock.

Each write channel runs a two-state machine. In CH_IDLE, a write moves it to CH_PEND, latches the data and flips the request toggle. In CH_PEND, the acknowledge toggle coming back equal to the request returns it to CH_IDLE. The interrupt flag is also a two-state machine. In FLG_CLEAR, an arriving match event moves it to FLG_SET. In FLG_SET, a clear request with no match event arriving in the same cycle returns it to FLG_CLEAR.

Top module: `tmr_xdom_bridge`

## Requirements
- R1: A bus write with `wr_sel` = 0 (control), 1 (counter) or 2 (compare) sets `busy[wr_sel]` from the next bus edge on and leaves the other busy bits unchanged. `wr_sel` = 3 addresses no register.
- R2: A busy bit returns to 0 only after the value has been loaded in the timer domain. This happens no sooner than one timer-clock period after the write edge. A counter value written while stopped is then seen in the snapshot.
- R3: A write to a register whose busy bit is 1 is ignored, and the value already pending is the one that is loaded.
- R4: While control bit 0 (run) is 1, the counter increments by one on every timer-clock edge and wraps from 255 to 0. While run is 0 it holds its value.
- R5: `cnt_snap` is a bus-domain register reloaded with the counter after every timer-clock edge. If the bus clock stops and restarts, it keeps the value from before the stop until a later timer edge has been carried across.
- R6: A match occurs on a timer edge where run is 1 and the counter equals the compare value. With control bit 1 set, `cmp_pin` toggles on that same timer edge and at no other time. A free-running counter matches every 256 timer edges.
- R7: `cmp_flag` rises on the third bus-clock edge after the matching timer edge. At that point the snapshot already shows the compare value plus one.
- R8: Pulsing `flag_clr` clears `cmp_flag`. If a match event arrives in the same cycle as the clear, the flag stays set.
- R9: Bus reset clears the busy bits, `cnt_snap` and `cmp_flag`. Timer reset clears the counter, compare, control and `cmp_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Bus-domain reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 counter, 2 compare |
| wr_data | input | 8 | Write data |
| flag_clr | input | 1 | Clear request for the interrupt flag |
| busy | output | 3 | Per-register update-busy bits, indexed by `wr_sel` |
| cnt_snap | output | 8 | Counter snapshot in the bus domain |
| cmp_flag | output | 1 | Compare-match interrupt flag |
| tmr_clk | input | 1 | Slow timer clock |
| tmr_rst_n | input | 1 | Timer-domain reset, active low |
| cmp_pin | output | 1 | Compare output pin, timer-clock driven |

## Verification
A handshake toggle left in the wrong state shows at the ports in one of two ways. Either a busy bit never falls, or a write of one value lands a different value in the snapshot within a few timer periods. The bench writes every counter value and reads it back to expose the second case. A miscounted synchronizer stage shifts the flag by a whole bus cycle against the pin edge, so the edge counting catches it at the first match. A snapshot that is not reloaded on every timer edge breaks the running-count invariant within one timer period.

// File: rtl/tmr_xdom_pkg.sv
package tmr_xdom_pkg;

    localparam int NUM_REGS = 3;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_PEND = 1'b1
    } chan_st_e;

    typedef enum logic {
        FLG_CLEAR = 1'b0,
        FLG_SET   = 1'b1
    } flag_st_e;

endpackage

// File: rtl/tmr_xdom_sync.sv
module tmr_xdom_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tmr_xdom_wr_chan.sv
module tmr_xdom_wr_chan
    import tmr_xdom_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         bus_clk,
    input  logic         bus_rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic         busy,
    input  logic         tmr_clk,
    input  logic         tmr_rst_n,
    output logic         ld,
    output logic [W-1:0] ldata
);
    chan_st_e     st_q, st_d;
    logic         req_q, ack_bus, req_tmr, seen_q;
    logic [W-1:0] data_q;

    // bus side: state register
    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) st_q <= CH_IDLE;
        else            st_q <= st_d;
    end

    // bus side: next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_IDLE: if (wr)                st_d = CH_PEND;
            CH_PEND: if (ack_bus == req_q)  st_d = CH_IDLE;
        endcase
    end

    // bus side: staging register and request toggle
    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) begin
            req_q  <= 1'b0;
            data_q <= '0;
        end else if (st_q == CH_IDLE && wr) begin
            req_q  <= ~req_q;
            data_q <= wdata;
        end
    end

    assign busy = (st_q == CH_PEND);

    // timer side: request detect and acknowledge
    tmr_xdom_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(tmr_clk), .rst_n(tmr_rst_n), .d(req_q), .q(req_tmr)
    );

    always_ff @(posedge tmr_clk or negedge tmr_rst_n) begin
        if (!tmr_rst_n) seen_q <= 1'b0;
        else            seen_q <= req_tmr;
    end

    assign ld    = req_tmr ^ seen_q;
    assign ldata = data_q;

    tmr_xdom_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(seen_q), .q(ack_bus)
    );

    // R1
    wr_accept_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (st_q == CH_IDLE && wr) |=> busy);

    // R3
    pend_hold_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (busy && wr) |=> $stable(data_q));
endmodule

// File: rtl/tmr_xdom_core.sv
module tmr_xdom_core #(
    parameter int W     = 8,
    parameter int CTL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_ctl,
    input  logic [CTL_W-1:0] ctl_d,
    input  logic             ld_cnt,
    input  logic [W-1:0]     cnt_d,
    input  logic             ld_cmp,
    input  logic [W-1:0]     cmp_d,
    output logic [W-1:0]     cnt,
    output logic             tick,
    output logic             match_tgl,
    output logic             pin
);
    logic [CTL_W-1:0] ctl_q;
    logic [W-1:0]     cnt_q, cmp_q;
    logic             run, pin_en, hit;

    assign run    = ctl_q[0];
    assign pin_en = ctl_q[1];
    assign hit    = run && (cnt_q == cmp_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            cmp_q     <= '0;
            cnt_q     <= '0;
            tick      <= 1'b0;
            match_tgl <= 1'b0;
            pin       <= 1'b0;
        end else begin
            if (ld_ctl) ctl_q <= ctl_d;
            if (ld_cmp) cmp_q <= cmp_d;
            if (ld_cnt)   cnt_q <= cnt_d;
            else if (run) cnt_q <= cnt_q + 1'b1;
            tick <= ~tick;
            if (hit) begin
                match_tgl <= ~match_tgl;
                if (pin_en) pin <= ~pin;
            end
        end
    end

    assign cnt = cnt_q;

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ld_cnt) |=> (cnt_q == $past(cnt_q) + W'(1)));

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ld_cnt) |=> $stable(cnt_q));

    // R6
    pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && pin_en) |=> $stable(pin));
endmodule

// File: rtl/tmr_xdom_bridge.sv
module tmr_xdom_bridge
    import tmr_xdom_pkg::*;
#(
    parameter int W           = 8,
    parameter int CTL_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                bus_clk,
    input  logic                bus_rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [W-1:0]        wr_data,
    input  logic                flag_clr,
    output logic [NUM_REGS-1:0] busy,
    output logic [W-1:0]        cnt_snap,
    output logic                cmp_flag,
    input  logic                tmr_clk,
    input  logic                tmr_rst_n,
    output logic                cmp_pin
);
    logic             wr_ctl, wr_cnt, wr_cmp;
    logic             ld_ctl, ld_cnt, ld_cmp;
    logic [CTL_W-1:0] ctl_t;
    logic [W-1:0]     cnt_t, cmp_t, cnt_live;
    logic             tick_t, match_t;
    logic             tick_b, tick_seen_q, tick_new;
    logic             match_b, match_seen_q, match_new;
    flag_st_e         flg_q, flg_d;

    assign wr_ctl = wr_en && (wr_sel == 2'd0);
    assign wr_cnt = wr_en && (wr_sel == 2'd1);
    assign wr_cmp = wr_en && (wr_sel == 2'd2);

    tmr_xdom_wr_chan #(.W(CTL_W), .SYNC_STAGES(SYNC_STAGES)) u_ctl_chan (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr(wr_ctl),
        .wdata(wr_data[CTL_W-1:0]), .busy(busy[0]),
        .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n), .ld(ld_ctl), .ldata(ctl_t)
    );

    tmr_xdom_wr_chan #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_cnt_chan (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr(wr_cnt),
        .wdata(wr_data), .busy(busy[1]),
        .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n), .ld(ld_cnt), .ldata(cnt_t)
    );

    tmr_xdom_wr_chan #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_cmp_chan (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr(wr_cmp),
        .wdata(wr_data), .busy(busy[2]),
        .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n), .ld(ld_cmp), .ldata(cmp_t)
    );

    tmr_xdom_core #(.W(W), .CTL_W(CTL_W)) u_core (
        .clk(tmr_clk), .rst_n(tmr_rst_n),
        .ld_ctl(ld_ctl), .ctl_d(ctl_t),
        .ld_cnt(ld_cnt), .cnt_d(cnt_t),
        .ld_cmp(ld_cmp), .cmp_d(cmp_t),
        .cnt(cnt_live), .tick(tick_t), .match_tgl(match_t), .pin(cmp_pin)
    );

    // snapshot: capture the counter once per carried-over timer edge
    tmr_xdom_sync #(.STAGES(SYNC_STAGES)) u_tick_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(tick_t), .q(tick_b)
    );
    tmr_xdom_sync #(.STAGES(SYNC_STAGES)) u_match_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(match_t), .q(match_b)
    );

    assign tick_new  = tick_b ^ tick_seen_q;
    assign match_new = match_b ^ match_seen_q;

    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) begin
            tick_seen_q  <= 1'b0;
            match_seen_q <= 1'b0;
            cnt_snap     <= '0;
        end else begin
            tick_seen_q  <= tick_b;
            match_seen_q <= match_b;
            if (tick_new) cnt_snap <= cnt_live;
        end
    end

    // flag state register
    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) flg_q <= FLG_CLEAR;
        else            flg_q <= flg_d;
    end

    always_comb begin
        flg_d = flg_q;
        unique case (flg_q)
            FLG_CLEAR: if (match_new)              flg_d = FLG_SET;
            FLG_SET:   if (flag_clr && !match_new) flg_d = FLG_CLEAR;
        endcase
    end

    // flag output
    always_comb cmp_flag = (flg_q == FLG_SET);

    // R8
    set_wins_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        match_new |=> cmp_flag);

    // R7
    flag_src_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $rose(cmp_flag) |-> $past(match_new));

    // R5
    snap_hold_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !tick_new |=> $stable(cnt_snap));
endmodule

// File: tb/tmr_xdom_bridge_bench.sv
module tmr_xdom_bridge_bench;
    logic       bus_clk = 1'b0;
    logic       tmr_clk = 1'b0;
    logic       bus_run = 1'b1;
    logic       bus_rst_n, tmr_rst_n;
    logic       wr_en, flag_clr;
    logic [1:0] wr_sel;
    logic [7:0] wr_data;
    logic [2:0] busy;
    logic [7:0] cnt_snap;
    logic       cmp_flag, cmp_pin;

    int vectors = 0;
    int miscompares = 0;
    int tedges = 0;

    tmr_xdom_bridge u_tmr_xdom_bridge (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .flag_clr(flag_clr), .busy(busy), .cnt_snap(cnt_snap),
        .cmp_flag(cmp_flag), .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n), .cmp_pin(cmp_pin)
    );

    // 100 MHz bus clock that can be held low
    always begin
        #5;
        if (bus_run) bus_clk = ~bus_clk;
    end

    // timer clock, 80 ns period, rising edges at 43 + 80k
    initial begin
        #3;
        forever #40 tmr_clk = ~tmr_clk;
    end

    always @(posedge tmr_clk) tedges <= tedges + 1;

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic bus_write(input logic [1:0] s, input logic [7:0] d);
        @(negedge bus_clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge bus_clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy != 3'b000) @(negedge bus_clk);
    endtask

    task automatic settle();
        repeat (2) @(posedge tmr_clk);
        repeat (4) @(negedge bus_clk);
    endtask

    task automatic wait_snap_change();
        logic [7:0] s0;
        s0 = cnt_snap;
        while (cnt_snap == s0) @(negedge bus_clk);
    endtask

    initial begin
        #1_500_000;
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [7:0] base, s, p;
        int e0, t0, t1, m0;
        bus_rst_n = 1'b0; tmr_rst_n = 1'b0;
        wr_en = 1'b0; wr_sel = 2'd0; wr_data = 8'd0; flag_clr = 1'b0;
        #200;
        @(negedge bus_clk);
        bus_rst_n = 1'b1; tmr_rst_n = 1'b1;

        // R9 reset state
        chk("R9 busy", busy, 0);
        chk("R9 snap", cnt_snap, 0);
        chk("R9 flag", cmp_flag, 0);
        chk("R9 pin", cmp_pin, 0);

        // R1 per-register busy bits
        bus_write(2'd2, 8'd5);
        t0 = $time;
        chk("R1 cmp busy", busy, 3'b100);
        bus_write(2'd0, 8'd0);
        chk("R1 ctl busy", busy, 3'b101);
        bus_write(2'd3, 8'd9);
        chk("R1 sel3 no busy bit", busy[1], 0);
        while (busy[2]) @(negedge bus_clk);
        t1 = $time;
        // R2 at least one timer period from write edge to clear
        chk("R2 busy min time", (t1 - t0 + 5 >= 80) ? 1 : 0, 1);
        wait_idle();

        // R2 sweep of every counter value, R3 ignored write at 77
        for (int v = 0; v < 256; v++) begin
            bus_write(2'd1, 8'(v));
            if (v == 77) begin
                bus_write(2'd1, 8'd200);
                chk("R3 still busy", busy[1], 1);
            end
            wait_idle();
            settle();
            if (v == 77) chk("R3 ignored write", cnt_snap, 77);
            else         chk("R2 counter load", cnt_snap, v);
        end

        // R4 hold while stopped
        s = cnt_snap;
        repeat (4) @(posedge tmr_clk);
        repeat (4) @(negedge bus_clk);
        chk("R4 hold stopped", cnt_snap, s);

        // R4 running count with wrap, R5 reload per edge
        bus_write(2'd0, 8'd1);
        wait_idle();
        wait_snap_change();
        base = cnt_snap; e0 = tedges;
        for (int i = 0; i < 20; i++) begin
            wait_snap_change();
            chk("R4 count step", cnt_snap, 8'(base + 8'(tedges - e0)));
        end

        // R5 bus clock stop and restart
        wait_snap_change();
        base = cnt_snap; e0 = tedges;
        bus_run = 1'b0;
        #302;
        bus_run = 1'b1;
        @(negedge bus_clk);
        chk("R5 stale after restart", cnt_snap, base);
        wait_snap_change();
        chk("R5 refresh after restart", cnt_snap, 8'(base + 8'(tedges - e0)));

        // stop, check hold
        bus_write(2'd0, 8'd0);
        wait_idle();
        settle();
        s = cnt_snap;
        repeat (4) @(posedge tmr_clk);
        repeat (4) @(negedge bus_clk);
        chk("R4 hold after stop", cnt_snap, s);

        // R7 the run passed compare=5, R8 clear
        chk("R7 flag from earlier match", cmp_flag, 1);
        @(negedge bus_clk); flag_clr = 1'b1;
        @(negedge bus_clk); flag_clr = 1'b0;
        chk("R8 clear", cmp_flag, 0);

        // R6 and R7 with compare 20 and pin enabled
        bus_write(2'd1, 8'd0);
        bus_write(2'd2, 8'd20);
        wait_idle();
        bus_write(2'd0, 8'd3);
        wait_idle();
        p = {7'd0, cmp_pin};
        wait (cmp_pin != p[0]);
        chk("R6 pin on timer edge", int'(($time - 43) % 80), 0);
        chk("R7 snap before flag", cnt_snap, 20);
        chk("R7 flag not yet", cmp_flag, 0);
        #1;
        m0 = tedges;
        repeat (2) @(posedge bus_clk);
        @(negedge bus_clk);
        chk("R7 flag after two bus edges", cmp_flag, 0);
        @(posedge bus_clk);
        @(negedge bus_clk);
        chk("R7 flag on third bus edge", cmp_flag, 1);
        chk("R7 counter advanced", cnt_snap, 21);

        // R8 clear colliding with next match
        p = {7'd0, cmp_pin};
        wait (cmp_pin != p[0]);
        #1;
        chk("R6 match period", tedges - m0, 256);
        repeat (2) @(posedge bus_clk);
        @(negedge bus_clk); flag_clr = 1'b1;
        @(posedge bus_clk);
        @(negedge bus_clk); flag_clr = 1'b0;
        chk("R8 set wins over clear", cmp_flag, 1);
        @(negedge bus_clk); flag_clr = 1'b1;
        @(negedge bus_clk); flag_clr = 1'b0;
        chk("R8 clear after collision", cmp_flag, 0);

        // R9 resets mid-run, pin high after third match
        p = {7'd0, cmp_pin};
        wait (cmp_pin != p[0]);
        repeat (6) @(negedge bus_clk);
        chk("R6 pin toggled high", cmp_pin, 1);
        chk("R7 flag set again", cmp_flag, 1);
        tmr_rst_n = 1'b0;
        repeat (2) @(negedge bus_clk);
        chk("R9 timer reset pin", cmp_pin, 0);
        bus_rst_n = 1'b0;
        repeat (2) @(negedge bus_clk);
        chk("R9 bus reset flag", cmp_flag, 0);
        chk("R9 bus reset snap", cnt_snap, 0);
        chk("R9 bus reset busy", busy, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule